// File: doc/BRIEF.md
# Round-Robin Memory Command Arbiter

This block sits in front of a memory controller and decides which of eight request channels gets the next command slot. Each channel presents a request bit, an address and a read/not-write flag. The arbiter works in fixed slots of four clock cycles. The first three cycles of a slot are idle spacing. The fourth cycle is the decision cycle, and a decision is made there only while the controller's ready input is high. A rotating start pointer makes the grant order fair, so a channel that keeps requesting cannot win twice in a row while another channel is waiting.

Two kinds of command preempt normal grants. After reset, the arbiter first runs a fixed power-up phase of initialise commands, counted by an extra top bit of the slot counter. After that, a free-running down-counter raises a refresh command at regular intervals. A refresh takes precedence over any grant. All outputs are registered, so a command becomes visible in the cycle after its decision edge.

Top module: `mem_cmd_arbiter`

## Requirements
- R1: In each decision, the search for a winner starts at the channel held in the rotating pointer and goes upward modulo 8. The first channel with its request bit set wins. The grant vector then has exactly one bit set, at that channel's position (bit n = channel n).
- R2: After a grant, the pointer becomes the winner's index plus one, modulo 8. When no grant is made, the pointer keeps its value. A channel that stays active is therefore served again only after every other active channel has been served.
- R3: Each command is preceded by three idle cycles in which the strobe and the grant vector are zero. With ready held high and requests present, strobes occur exactly four cycles apart.
- R4: A decision is taken only on a clock edge where the ready input is high. While ready is low, no strobe occurs. If ready rises while the slot is waiting in its decision cycle, the strobe appears in the cycle after the next clock edge.
- R5: A grant drives the command code to {1, rnw of the winner}. It drives the address output to the winner's address, which is field [n*ADDR_W +: ADDR_W] of the address bus for channel n.
- R6: The refresh timer reloads with RFSH_RELOAD and counts down by one each cycle until its top bit sets. The first decision cycle with ready high after that point issues code 2'b01 with an all-zero grant vector, reloads the timer, and leaves the pointer unchanged. With RFSH_RELOAD=63 and ready and all requests held high, two refreshes are 68 cycles apart, with 16 grants between them.
- R7: After reset is released, the first 8 commands are initialise commands (code 2'b00, grant vector zero), four cycles apart. Arbitration then starts with the pointer at channel 0.
- R8: While reset (active low) is asserted, the strobe and the grant vector are zero in the cycle after each clock edge.
- R9: The strobe is high for exactly one cycle per command. It stays low when no channel requests and no refresh or initialise command is due.
- R10: The address output and the command code keep their values in every cycle without a strobe. A refresh or initialise command does not change the address output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_ready | input | 1 | Controller can accept the next command |
| ch_req | input | 8 | Request bit per channel |
| ch_rnw | input | 8 | Read (1) / write (0) flag per channel |
| ch_addr | input | 8*ADDR_W | Channel addresses, channel n at [n*ADDR_W +: ADDR_W] |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 2 | 00 initialise, 01 refresh, 1x read/write with bit 0 = rnw |
| cmd_addr | output | ADDR_W | Address of the granted channel |
| ch_grant | output | 8 | One-hot grant, zero for non-grant commands |

## Verification
The hardest situation to reach from the ports is a refresh that falls between two grants while the pointer is part-way round the ring. The bench must then show that the grant after the refresh continues exactly where the rotation left off. The bench shortens the refresh period through the parameters and holds every request high for a long stretch. It measures the spacing between two refreshes, counts the grants between them, and checks the winner that follows. The vector walk also changes the request pattern right after each strobe, so that wrap-around, a single active channel and alternating pairs are each decided from a known pointer value.

// File: rtl/arb_pkg.sv
// Package: arb_pkg
// Shared constants and types for the round-robin memory command arbiter.
// Assumes a fixed ring of eight channels and a four-cycle command slot.
package arb_pkg;
    localparam int NUM_CH    = 8;
    localparam int CH_IDX_W  = $clog2(NUM_CH);
    localparam int PHASE_W   = 2;
    localparam int SLOT_W    = 1 + CH_IDX_W + PHASE_W;

    localparam logic [1:0] CODE_INIT = 2'b00;
    localparam logic [1:0] CODE_RFSH = 2'b01;

    // What the current cycle decides to issue
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_RFSH  = 2'd1,
        ACT_INIT  = 2'd2,
        ACT_GRANT = 2'd3
    } act_e;
endpackage

// File: rtl/arb_rr_pick.sv
// Module: arb_rr_pick
// Combinational rotating finder. It returns the first requesting channel
// at or above start_i, wrapping modulo NUM_CH.
// Assumes NUM_CH is a power of two, so that index arithmetic wraps naturally.
module arb_rr_pick
    import arb_pkg::*;
(
    input  logic [NUM_CH-1:0]   req_i,
    input  logic [CH_IDX_W-1:0] start_i,
    output logic                hit_o,
    output logic [CH_IDX_W-1:0] win_o
);
    logic [2*NUM_CH-1:0] dbl_req;
    logic [NUM_CH-1:0]   rot_req;
    logic [CH_IDX_W-1:0] offset;

    assign dbl_req = {req_i, req_i};
    assign rot_req = dbl_req[start_i +: NUM_CH];

    // Lowest set bit of the rotated vector gives the distance from the start
    always_comb begin
        offset = '0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            if (rot_req[k]) offset = CH_IDX_W'(k);
        end
    end

    assign hit_o = |req_i;
    assign win_o = start_i + offset;
endmodule

// File: rtl/arb_refresh_timer.sv
// Module: arb_refresh_timer
// Refresh interval timer. Loads RELOAD and counts down until its top bit
// sets, then holds and flags due_o until reload_i restarts it.
// Assumes RELOAD fits in TMR_W-1 bits.
module arb_refresh_timer #(
    parameter int TMR_W  = 16,
    parameter int RELOAD = 32767
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload_i,
    output logic due_o
);
    localparam logic [TMR_W-1:0] RELOAD_V = TMR_W'(RELOAD);

    logic [TMR_W-1:0] tmr_q;

    // Count down, reload on a refresh command or on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= RELOAD_V;
        end else if (reload_i) begin
            tmr_q <= RELOAD_V;
        end else if (!tmr_q[TMR_W-1]) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    assign due_o = tmr_q[TMR_W-1];
endmodule

// File: rtl/arb_slot_ctrl.sv
// Module: arb_slot_ctrl
// Slot sequencer. It holds one counter of the form {boot, pointer, phase}.
// Phases 0..2 are idle. Phase 3 decides, if ready_i is high, between
// refresh, initialise and grant, in that order of precedence.
// The boot bit is set by reset. It is cleared by the carry after 32 steps.
module arb_slot_ctrl
    import arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ready_i,
    input  logic                due_i,
    input  logic                hit_i,
    input  logic [CH_IDX_W-1:0] win_i,
    output act_e                act_o,
    output logic [CH_IDX_W-1:0] ptr_o
);
    localparam logic [PHASE_W-1:0] PH_DECIDE = '1;
    localparam logic [SLOT_W-1:0]  SLOT_RST  = {1'b1, {(SLOT_W-1){1'b0}}};

    logic [SLOT_W-1:0]   slot_q;
    logic [PHASE_W-1:0]  phase;
    logic                boot;
    logic [CH_IDX_W-1:0] ptr_next;

    assign phase    = slot_q[PHASE_W-1:0];
    assign ptr_o    = slot_q[PHASE_W +: CH_IDX_W];
    assign boot     = slot_q[SLOT_W-1];
    assign ptr_next = win_i + 1'b1;

    // Choose what the current cycle issues
    always_comb begin
        act_o = ACT_NONE;
        if (phase == PH_DECIDE && ready_i) begin
            if (due_i)      act_o = ACT_RFSH;
            else if (boot)  act_o = ACT_INIT;
            else if (hit_i) act_o = ACT_GRANT;
        end
    end

    // Advance the slot counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_RST;
        end else if (phase != PH_DECIDE) begin
            slot_q <= slot_q + 1'b1;
        end else begin
            case (act_o)
                ACT_RFSH:  slot_q[PHASE_W-1:0] <= '0;
                ACT_INIT:  slot_q <= slot_q + 1'b1;
                ACT_GRANT: slot_q <= {1'b0, ptr_next, {PHASE_W{1'b0}}};
                default:   slot_q <= slot_q;
            endcase
        end
    end
endmodule

// File: rtl/mem_cmd_arbiter.sv
// Module: mem_cmd_arbiter
// Top level of the round-robin memory command arbiter. Eight channels share
// one controller command port. Every output is registered.
// Assumes ch_req, ch_rnw and ch_addr are synchronous to clk.
module mem_cmd_arbiter
    import arb_pkg::*;
#(
    parameter int ADDR_W      = 21,
    parameter int RFSH_W      = 16,
    parameter int RFSH_RELOAD = 32767
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctrl_ready,
    input  logic [NUM_CH-1:0]        ch_req,
    input  logic [NUM_CH-1:0]        ch_rnw,
    input  logic [NUM_CH*ADDR_W-1:0] ch_addr,
    output logic                     cmd_valid,
    output logic [1:0]               cmd_code,
    output logic [ADDR_W-1:0]        cmd_addr,
    output logic [NUM_CH-1:0]        ch_grant
);
    logic [ADDR_W-1:0]   addr_arr [NUM_CH];
    logic                hit;
    logic [CH_IDX_W-1:0] win;
    logic [CH_IDX_W-1:0] ptr;
    logic                due;
    act_e                act;

    // Unpack the flat address bus into one word per channel
    for (genvar g = 0; g < NUM_CH; g++) begin : g_addr
        assign addr_arr[g] = ch_addr[g*ADDR_W +: ADDR_W];
    end

    arb_rr_pick u_pick (
        .req_i   (ch_req),
        .start_i (ptr),
        .hit_o   (hit),
        .win_o   (win)
    );

    arb_refresh_timer #(
        .TMR_W  (RFSH_W),
        .RELOAD (RFSH_RELOAD)
    ) u_rfsh (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (act == ACT_RFSH),
        .due_o    (due)
    );

    arb_slot_ctrl u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_i (ctrl_ready),
        .due_i   (due),
        .hit_i   (hit),
        .win_i   (win),
        .act_o   (act),
        .ptr_o   (ptr)
    );

    // Register the command outputs; code and address hold without a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_code  <= CODE_INIT;
            cmd_addr  <= '0;
            ch_grant  <= '0;
        end else begin
            cmd_valid <= (act != ACT_NONE);
            ch_grant  <= '0;
            case (act)
                ACT_RFSH: cmd_code <= CODE_RFSH;
                ACT_INIT: cmd_code <= CODE_INIT;
                ACT_GRANT: begin
                    cmd_code <= {1'b1, ch_rnw[win]};
                    cmd_addr <= addr_arr[win];
                    ch_grant <= NUM_CH'(1) << win;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/arb_checker.sv
// Module: arb_checker
// Temporal checks on the arbiter ports. It is attached to every
// mem_cmd_arbiter instance by the bind statement at the end of this file.
module arb_checker
    import arb_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_ready,
    input logic [NUM_CH-1:0] ch_rnw,
    input logic              cmd_valid,
    input logic [1:0]        cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [NUM_CH-1:0] ch_grant
);
    // R8: reset forces a quiet port
    a_r8_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && ch_grant == '0));

    // R3: three idle cycles follow every command
    a_r3_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid ##1 !cmd_valid ##1 !cmd_valid);

    // R9: strobe is a single-cycle pulse
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R4: no decision without ready
    a_r4_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_ready |=> !cmd_valid);

    // R1: a read/write command carries exactly one grant bit
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code[1]) |-> $countones(ch_grant) == 1);

    // R5: a grant only appears with a read/write strobe
    a_r5_grant_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_grant != '0) |-> (cmd_valid && cmd_code[1]));

    // R5: code bit 0 follows the winner's read/not-write flag
    a_r5_rnw_match: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code[1]) |-> cmd_code[0] == |($past(ch_rnw) & ch_grant));

    // R6: refresh carries no grant
    a_r6_refresh_nogrant: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CODE_RFSH) |-> ch_grant == '0);

    // R10: address and code hold between strobes
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> $stable(cmd_addr));
    a_r10_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> $stable(cmd_code));
endmodule

bind mem_cmd_arbiter arb_checker #(.ADDR_W(ADDR_W)) u_arb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_ready (ctrl_ready),
    .ch_rnw     (ch_rnw),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .cmd_addr   (cmd_addr),
    .ch_grant   (ch_grant)
);

// File: tb/test_mem_cmd_arbiter.sv
// Bench for mem_cmd_arbiter. It walks a vector table of request patterns,
// then runs directed tests for refresh, ready, idle and mid-run reset.
module test_mem_cmd_arbiter;
    import arb_pkg::*;

    localparam int  AW   = 21;
    localparam int  TW   = 7;
    localparam int  RLD  = 63;
    localparam time TCK  = 20ns;
    localparam logic [7:0] RNW_PAT = 8'b0110_1001;
    localparam int  NENT = 16;
    // {request pattern, expected winner}, applied in order from pointer 1
    localparam logic [10:0] TBL [NENT] = '{
        {8'hFF, 3'd1}, {8'hFF, 3'd2}, {8'h01, 3'd0}, {8'h81, 3'd7},
        {8'h81, 3'd0}, {8'h81, 3'd7}, {8'h10, 3'd4}, {8'h10, 3'd4},
        {8'h30, 3'd5}, {8'h30, 3'd4}, {8'h40, 3'd6}, {8'h41, 3'd0},
        {8'h02, 3'd1}, {8'h0C, 3'd2}, {8'h0C, 3'd3}, {8'h0C, 3'd2}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ready = 1'b0;
    logic [7:0]      req = 8'h00;
    logic [8*AW-1:0] addr_bus;
    logic            cmd_valid;
    logic [1:0]      cmd_code;
    logic [AW-1:0]   cmd_addr;
    logic [7:0]      ch_grant;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(TCK/2) clk = ~clk;

    mem_cmd_arbiter #(.ADDR_W(AW), .RFSH_W(TW), .RFSH_RELOAD(RLD)) i_mem_cmd_arbiter (
        .clk(clk), .rst_n(rst_n), .ctrl_ready(ready), .ch_req(req),
        .ch_rnw(RNW_PAT), .ch_addr(addr_bus), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .ch_grant(ch_grant)
    );

    function automatic logic [AW-1:0] chan_addr(int n);
        return AW'(32'h0_4000 + n * 32'h1357);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Wait for the next strobe; gap counts negedges since the call
    task automatic next_cmd(output logic [1:0] c, output logic [7:0] g,
                            output logic [AW-1:0] a, output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!cmd_valid && gap < 400);
        c = cmd_code; g = ch_grant; a = cmd_addr;
    endtask

    // Wait for the next non-refresh strobe, checking any refresh on the way
    task automatic next_grant(output logic [1:0] c, output logic [7:0] g,
                              output logic [AW-1:0] a, output int gap, output int refs);
        refs = 0;
        forever begin
            next_cmd(c, g, a, gap);
            if (c != CODE_RFSH || gap >= 400) break;
            refs++;
            chk("R6 refresh grant", 32'(g), 0);
        end
    endtask

    function automatic int idx_of(logic [7:0] g);
        int r = -1;
        for (int i = 0; i < 8; i++) if (g[i]) r = i;
        return r;
    endfunction

    task automatic check_boot();
        logic [1:0] c; logic [7:0] g; logic [AW-1:0] a; int gap;
        for (int i = 0; i < 8; i++) begin
            next_cmd(c, g, a, gap);
            chk("R7 init code", 32'(c), 32'(CODE_INIT));
            chk("R7 init grant", 32'(g), 0);
            if (i > 0) chk("R3 init spacing", 32'(gap), 4);
        end
        next_cmd(c, g, a, gap);
        chk("R7 first grant channel 0", 32'(g), 32'h01);
        chk("R3 spacing after init", 32'(gap), 4);
    endtask

    initial begin
        for (int n = 0; n < 8; n++) addr_bus[n*AW +: AW] = chan_addr(n);
    end

    initial begin
        #(TCK * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [1:0] c; logic [7:0] g; logic [AW-1:0] a; int gap; int refs;
        ready = 1'b1;
        req = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R8 strobe in reset", 32'(cmd_valid), 0);
        chk("R8 grant in reset", 32'(ch_grant), 0);
        rst_n = 1'b1;
        check_boot();

        // Vector walk: R1, R2, R3, R5
        for (int e = 0; e < NENT; e++) begin
            int w;
            w = int'(TBL[e][2:0]);
            req = TBL[e][10:3];
            next_grant(c, g, a, gap, refs);
            chk($sformatf("R1 R2 entry %0d winner", e), 32'(g), 32'(8'h01 << w));
            chk($sformatf("R5 entry %0d code", e), 32'(c), 32'({1'b1, RNW_PAT[w]}));
            chk($sformatf("R5 entry %0d addr", e), 32'(a), 32'(chan_addr(w)));
            if (refs == 0) chk($sformatf("R3 entry %0d spacing", e), 32'(gap), 4);
        end

        // R6: refresh interval, grants in between, pointer preserved
        begin
            int t; int grants; int last_w; int guard;
            req = 8'hFF;
            guard = 0;
            do begin
                next_cmd(c, g, a, gap);
                guard++;
            end while (c != CODE_RFSH && guard < 40);
            chk("R6 first refresh seen", 32'(c), 32'(CODE_RFSH));
            t = 0; grants = 0; last_w = 0; guard = 0;
            forever begin
                next_cmd(c, g, a, gap);
                t += gap;
                guard++;
                if (c == CODE_RFSH || guard > 40) break;
                grants++;
                last_w = idx_of(g);
            end
            chk("R6 refresh interval", 32'(t), 68);
            chk("R6 grants between refreshes", 32'(grants), 16);
            next_cmd(c, g, a, gap);
            chk("R6 pointer kept over refresh", 32'(g), 32'(8'h01 << ((last_w + 1) % 8)));
        end

        // R4: ready low blocks decisions, resume on rise
        begin
            int seen = 0;
            ready = 1'b0;
            repeat (30) begin
                @(negedge clk);
                if (cmd_valid) seen++;
            end
            chk("R4 no strobe while not ready", 32'(seen), 0);
            ready = 1'b1;
            @(negedge clk);
            chk("R4 strobe after ready rises", 32'(cmd_valid), 1);
        end

        // R9 / R10: idle channels, held address and code
        begin
            logic [1:0] c0; logic [AW-1:0] a0; int bad = 0; int rf = 0;
            next_grant(c0, g, a0, gap, refs);
            req = 8'h00;
            @(negedge clk);
            chk("R9 strobe lasts one cycle", 32'(cmd_valid), 0);
            repeat (60) begin
                @(negedge clk);
                if (cmd_valid) begin
                    if (cmd_code != CODE_RFSH || ch_grant != 8'h00) bad++;
                    else rf++;
                end
            end
            chk("R9 no grant strobe without requests", 32'(bad), 0);
            chk("R10 address held", 32'(cmd_addr), 32'(a0));
            if (rf == 0) chk("R10 code held", 32'(cmd_code), 32'(c0));
        end

        // R8 / R7: reset in mid-run, then power-up again
        req = 8'hFF;
        next_cmd(c, g, a, gap);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 strobe cleared by reset", 32'(cmd_valid), 0);
        chk("R8 grant cleared by reset", 32'(ch_grant), 0);
        @(negedge clk);
        rst_n = 1'b1;
        check_boot();

        report();
    end
endmodule